// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a multicycle 32-bit processor core that shares one memory and one ALU across the steps of an instruction. It takes the 6-bit opcode field of the instruction register and produces every datapath control line: memory read and write strobes, the memory address select, the instruction register load, the register file write and its destination and source selects, both ALU operand selects, the 2-bit ALU operation, the PC source select, and the unconditional and conditional PC write enables.

Every instruction starts with a fetch step and a decode step. During decode the ALU speculatively forms a branch target, before the opcode is known. The machine then branches by instruction class. Branches and jumps finish in 3 cycles. Stores and register-to-register operations finish in 4 cycles. Loads finish in 5 cycles. All outputs depend only on the current state (Moore style). The opcode is sampled only at the end of the decode step and at the end of the address step. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain level control signal.

Top module: `mcc_fsm`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it is released, the outputs show the fetch step.
- R2: Fetch step outputs: mem_rd=1, addr_sel=0, ir_load=1, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src=00, pc_wr=1. All other enables are 0.
- R3: The cycle after fetch is always the decode step, whatever the opcode: alu_a_sel=0, alu_b_sel=11, alu_op=00. Every enable is 0.
- R4: Load (opcode 0x23) takes 5 cycles. Cycle 3 is the address step (alu_a_sel=1, alu_b_sel=10, alu_op=00). Cycle 4 is mem_rd=1 with addr_sel=1. Cycle 5 is reg_wr=1 with wb_sel=1 and dst_sel=0.
- R5: Store (opcode 0x2B) takes 4 cycles. Cycle 3 is the address step. Cycle 4 is mem_wr=1 with addr_sel=1.
- R6: R-type (opcode 0x00) takes 4 cycles. Cycle 3 is alu_a_sel=1, alu_b_sel=00, alu_op=10. Cycle 4 is reg_wr=1 with dst_sel=1 and wb_sel=0.
- R7: Branch-if-equal (opcode 0x04) takes 3 cycles. Cycle 3 is alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01, pc_wr_cond=1.
- R8: Jump (opcode 0x02) takes 3 cycles. Cycle 3 is pc_src=10 with pc_wr=1.
- R9: Any other opcode returns to fetch right after decode. No memory, register or PC write is asserted in between.
- R10: mem_rd and mem_wr are never both 1. pc_wr and pc_wr_cond are never both 1.
- R11: The opcode is sampled only at the end of the decode and address steps. A change in any other cycle has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the fetch step |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| ir_load | output | 1 | Load the instruction register from memory |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| wb_sel | output | 1 | Write-back data: 0 = ALU result register, 1 = memory data register |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 = reg B, 01 = constant 4, 10 = sign-extended immediate, 11 = immediate shifted left by 2 |
| alu_op | output | 2 | 00 = add, 01 = subtract, 10 = use the funct field |
| pc_src | output | 2 | PC source: 00 = ALU output, 01 = ALU result register, 10 = jump target |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five opcode assignments in the requirements. With a 6-bit opcode, random draws cover all 64 codes, so the 59 unassigned codes reach the early-return path. Random opcodes are applied in every cycle where the opcode must be ignored, which exercises the sampling windows. A directed reset in the middle of a load checks that the sequence is abandoned and the machine returns to fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int ALU_OP_W  = 2;
  localparam int B_SEL_W   = 2;
  localparam int PC_SRC_W  = 2;
  localparam int STATE_W   = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MEM_RD  = 4'd3,
    ST_LOAD_WB = 4'd4,
    ST_MEM_WR  = 4'd5,
    ST_EXEC    = 4'd6,
    ST_ALU_WB  = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } mcc_state_t;

  typedef enum logic [2:0] {
    CL_LOAD, CL_STORE, CL_RTYPE, CL_BEQ, CL_JUMP, CL_NONE
  } mcc_class_t;

  typedef struct packed {
    logic                mem_rd;
    logic                mem_wr;
    logic                addr_sel;
    logic                ir_load;
    logic                reg_wr;
    logic                dst_sel;
    logic                wb_sel;
    logic                alu_a_sel;
    logic [B_SEL_W-1:0]  alu_b_sel;
    logic [ALU_OP_W-1:0] alu_op;
    logic [PC_SRC_W-1:0] pc_src;
    logic                pc_wr;
    logic                pc_wr_cond;
  } mcc_ctrl_t;

  localparam logic [B_SEL_W-1:0]  BSEL_REG   = 2'b00;
  localparam logic [B_SEL_W-1:0]  BSEL_FOUR  = 2'b01;
  localparam logic [B_SEL_W-1:0]  BSEL_IMM   = 2'b10;
  localparam logic [B_SEL_W-1:0]  BSEL_IMMSH = 2'b11;
  localparam logic [ALU_OP_W-1:0] AOP_ADD    = 2'b00;
  localparam logic [ALU_OP_W-1:0] AOP_SUB    = 2'b01;
  localparam logic [ALU_OP_W-1:0] AOP_FUNCT  = 2'b10;
  localparam logic [PC_SRC_W-1:0] PCS_ALU    = 2'b00;
  localparam logic [PC_SRC_W-1:0] PCS_TARGET = 2'b01;
  localparam logic [PC_SRC_W-1:0] PCS_JUMP   = 2'b10;
endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
  import mcc_pkg::*;
#(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OPC_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OPC_JUMP  = 6'h02
) (
  input  logic [OP_W-1:0] opcode,
  output mcc_class_t      op_class
);
  always_comb begin
    if (opcode == OPC_LOAD)       op_class = CL_LOAD;
    else if (opcode == OPC_STORE) op_class = CL_STORE;
    else if (opcode == OPC_RTYPE) op_class = CL_RTYPE;
    else if (opcode == OPC_BEQ)   op_class = CL_BEQ;
    else if (opcode == OPC_JUMP)  op_class = CL_JUMP;
    else                          op_class = CL_NONE;
  end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  mcc_state_t cur,
  input  mcc_class_t op_class,
  output mcc_state_t nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (op_class)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_RTYPE:          nxt = ST_EXEC;
          CL_BEQ:            nxt = ST_BRANCH;
          CL_JUMP:           nxt = ST_JUMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (op_class == CL_LOAD)       nxt = ST_MEM_RD;
        else if (op_class == CL_STORE) nxt = ST_MEM_WR;
        else                           nxt = ST_FETCH;
      end
      ST_MEM_RD: nxt = ST_LOAD_WB;
      ST_EXEC:   nxt = ST_ALU_WB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl_rom.sv
module mcc_ctrl_rom
  import mcc_pkg::*;
(
  input  mcc_state_t cur,
  output mcc_ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    case (cur)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_load   = 1'b1;
        ctrl.alu_b_sel = BSEL_FOUR;
        ctrl.alu_op    = AOP_ADD;
        ctrl.pc_src    = PCS_ALU;
        ctrl.pc_wr     = 1'b1;
      end
      ST_DECODE: begin
        ctrl.alu_b_sel = BSEL_IMMSH;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_IMM;
        ctrl.alu_op    = AOP_ADD;
      end
      ST_MEM_RD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LOAD_WB: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.wb_sel  = 1'b1;
        ctrl.dst_sel = 1'b0;
      end
      ST_MEM_WR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = BSEL_REG;
        ctrl.alu_op    = AOP_FUNCT;
      end
      ST_ALU_WB: begin
        ctrl.reg_wr  = 1'b1;
        ctrl.dst_sel = 1'b1;
        ctrl.wb_sel  = 1'b0;
      end
      ST_BRANCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_b_sel  = BSEL_REG;
        ctrl.alu_op     = AOP_SUB;
        ctrl.pc_src     = PCS_TARGET;
        ctrl.pc_wr_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl.pc_src = PCS_JUMP;
        ctrl.pc_wr  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_fsm.sv
module mcc_fsm
  import mcc_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OPC_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OPC_JUMP  = 6'h02
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opcode,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                addr_sel,
  output logic                ir_load,
  output logic                reg_wr,
  output logic                dst_sel,
  output logic                wb_sel,
  output logic                alu_a_sel,
  output logic [B_SEL_W-1:0]  alu_b_sel,
  output logic [ALU_OP_W-1:0] alu_op,
  output logic [PC_SRC_W-1:0] pc_src,
  output logic                pc_wr,
  output logic                pc_wr_cond
);
  mcc_state_t state_q, state_d;
  mcc_class_t op_class;
  mcc_ctrl_t  ctrl;

  mcc_opclass #(
    .OP_W(OP_W), .OPC_LOAD(OPC_LOAD), .OPC_STORE(OPC_STORE),
    .OPC_RTYPE(OPC_RTYPE), .OPC_BEQ(OPC_BEQ), .OPC_JUMP(OPC_JUMP)
  ) u_cls (
    .opcode  (opcode),
    .op_class(op_class)
  );

  mcc_next_state u_nxt (
    .cur     (state_q),
    .op_class(op_class),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  mcc_ctrl_rom u_rom (
    .cur (state_q),
    .ctrl(ctrl)
  );

  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign addr_sel   = ctrl.addr_sel;
  assign ir_load    = ctrl.ir_load;
  assign reg_wr     = ctrl.reg_wr;
  assign dst_sel    = ctrl.dst_sel;
  assign wb_sel     = ctrl.wb_sel;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign alu_op     = ctrl.alu_op;
  assign pc_src     = ctrl.pc_src;
  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
endmodule

// File: rtl/mcc_fsm_chk.sv
module mcc_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ir_load,
  input logic       reg_wr,
  input logic       dst_sel,
  input logic       wb_sel,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src,
  input logic       pc_wr,
  input logic       pc_wr_cond
);
  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_load && mem_rd && pc_wr));

  p_decode_follows_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11 && !mem_rd && !pc_wr && !reg_wr));

  p_load_read_then_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_wr && wb_sel && !dst_sel));

  p_store_then_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_load);

  p_rtype_wb_then_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && dst_sel) |=> ir_load);

  p_branch_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_load);

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

  p_pc_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_wr, pc_wr_cond}));
endmodule

bind mcc_fsm mcc_fsm_chk i_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .addr_sel(addr_sel), .ir_load(ir_load), .reg_wr(reg_wr),
  .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
  .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
  .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond)
);

// File: tb/test_mcc_fsm.sv
module test_mcc_fsm;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       mem_rd, mem_wr, addr_sel, ir_load, reg_wr, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic       pc_wr, pc_wr_cond;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_fsm i_mcc_fsm (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_load(ir_load),
    .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond)
  );

  // step codes: 0 fetch,1 decode,2 addr,3 mem read,4 load wb,5 mem write,6 exec,7 alu wb,8 branch,9 jump
  function automatic int op_kind(input logic [5:0] op);
    case (op)
      6'h23: return 0;
      6'h2B: return 1;
      6'h00: return 2;
      6'h04: return 3;
      6'h02: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int n_cycles(input int kind);
    case (kind)
      0: return 5;
      1, 2: return 4;
      3, 4: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int step_code(input int kind, input int k);
    if (k == 0) return 0;
    if (k == 1) return 1;
    case (kind)
      0: return (k == 2) ? 2 : (k == 3) ? 3 : 4;
      1: return (k == 2) ? 2 : 5;
      2: return (k == 2) ? 6 : 7;
      3: return 8;
      default: return 9;
    endcase
  endfunction

  // {mem_rd,mem_wr,addr_sel,ir_load,reg_wr,dst_sel,wb_sel,alu_a_sel,b[1:0],op[1:0],src[1:0],pc_wr,pc_wr_cond}
  function automatic logic [15:0] exp_vec(input int sc);
    case (sc)
      0: return 16'b1001_0000_01_00_00_1_0;
      1: return 16'b0000_0000_11_00_00_0_0;
      2: return 16'b0000_0001_10_00_00_0_0;
      3: return 16'b1010_0000_00_00_00_0_0;
      4: return 16'b0000_1010_00_00_00_0_0;
      5: return 16'b0110_0000_00_00_00_0_0;
      6: return 16'b0000_0001_00_10_00_0_0;
      7: return 16'b0000_1100_00_00_00_0_0;
      8: return 16'b0000_0001_00_01_01_0_1;
      default: return 16'b0000_0000_00_00_10_1_0;
    endcase
  endfunction

  function automatic string req_of(input int kind, input int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    case (kind)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] outs();
    return {mem_rd, mem_wr, addr_sel, ir_load, reg_wr, dst_sel, wb_sel, alu_a_sel,
            alu_b_sel, alu_op, pc_src, pc_wr, pc_wr_cond};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, outs(), exp);
    end
    if (mem_rd && mem_wr) begin
      bad++;
      $display("FAIL R10: actual mem_rd=1 mem_wr=1 expected not both");
    end
    if (pc_wr && pc_wr_cond) begin
      bad++;
      $display("FAIL R10: actual pc_wr=1 pc_wr_cond=1 expected not both");
    end
  endtask

  // Runs one instruction; called at a negedge with the machine in fetch.
  // The opcode is held only in decode and address steps (R11): random elsewhere.
  task automatic run_instr(input logic [5:0] op);
    int kind = op_kind(op);
    for (int k = 0; k < n_cycles(kind); k++) begin
      int sc = step_code(kind, k);
      check(req_of(kind, k), exp_vec(sc));
      if (sc == 1 || sc == 2) opcode = op;
      else                    opcode = 6'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", exp_vec(0));           // during reset
    rst = 1'b0;
    check("R1", exp_vec(0));           // first cycle after release
    // directed: each class once, plus unknown codes at both ends
    run_instr(6'h23);
    run_instr(6'h2B);
    run_instr(6'h00);
    run_instr(6'h04);
    run_instr(6'h02);
    run_instr(6'h3F);
    run_instr(6'h01);
    // reset in the middle of a load (R1)
    check("R2", exp_vec(0)); opcode = 6'h11; @(negedge clk);
    check("R3", exp_vec(1)); opcode = 6'h23; @(negedge clk);
    check("R4", exp_vec(2)); opcode = 6'h23; @(negedge clk);
    check("R4", exp_vec(3)); rst = 1'b1; @(negedge clk);
    check("R1", exp_vec(0)); rst = 1'b0;
    run_instr(6'h23);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      case ($urandom % 7)
        0: op = 6'h23;
        1: op = 6'h2B;
        2: op = 6'h00;
        3: op = 6'h04;
        4: op = 6'h02;
        default: op = 6'($urandom);
      endcase
      run_instr(op);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule